// File: doc/BRIEF.md
# Universal Registered Bus Transceiver

This block moves data between an A port and a B port, 18 bits wide, in two independent 9-bit halves. Each half has its own set of six control inputs. For each direction there is a latch enable, a storage clock and an active-low output enable. One storage element sits in each direction of each half. The latch enable and the storage clock together decide what that element does. It can pass the source port straight through, keep its contents, or take a new word on a rising edge of the storage clock.

Outputs are not tri-stated inside the block. Each output bit comes with an enable flag. When a direction is switched off, its flags are low and its data lines are zero. The chip-level pad logic turns each flag and data pair into a real three-state pin.

Storage updates happen on the rising edge of the system clock `clk`. The storage clocks are sampled there, and each sample is compared with the one taken at the previous edge. Each storage element has a two-state mode:
- **ST_PASS** applies while its latch enable is high.
- **ST_HOLD** applies while the latch enable is low.

The transitions are:
- **T_OPEN**: HOLD to PASS, when the latch enable rises.
- **T_CLOSE**: PASS to HOLD, when the latch enable falls.
- **T_CAPTURE**: HOLD to HOLD with a load, when a storage-clock rise is seen.
- **T_KEEP**: HOLD to HOLD with no load.

Top module: `ubus_xcvr`

## Requirements
- R1: When a direction's latch enable is high (ST_PASS), that direction's output data equals the source input in the same cycle, and the element stores the source at every `clk` rising edge.
- R2: When the latch enable is low and the storage clock shows no rise, the output holds the stored word even while the source input changes.
- R3: When the latch enable is low, a storage-clock rise loads the source input at that `clk` edge. A rise means the clock is 1 now and was 0 at the previous `clk` edge. A clock held at 1 or held at 0 loads nothing.
- R4: With output enable low (0), every enable flag of that half and direction is 1 and its data is the selected value. With output enable high (1), all its flags are 0 and all its data bits are 0. The stored word is kept either way.
- R5: B-to-A flow (`b_in` to `a_out`/`a_oe`) follows R1 to R4 using only the `ba_*` controls, and it never disturbs the A-to-B path.
- R6: Half h covers data bits [9h+8:9h] and is controlled only by bit h of each control vector. The two halves may run in different modes at once.
- R7: If the latch enable falls at the same `clk` edge where a storage-clock rise is seen, the input present at that edge is captured.
- R8: An active-low asynchronous `rst_n` clears all stored words to zero at once. A storage clock that is high when reset is released does not count as a rise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples controls and updates storage |
| rst_n | input | 1 | Asynchronous active-low reset |
| a_in | input | 18 | A-port data into the block |
| b_in | input | 18 | B-port data into the block |
| ab_le | input | 2 | A-to-B latch enable, one bit per half |
| ab_ck | input | 2 | A-to-B storage clock, one bit per half |
| ab_oe_n | input | 2 | A-to-B output enable, active low, one bit per half |
| ba_le | input | 2 | B-to-A latch enable, one bit per half |
| ba_ck | input | 2 | B-to-A storage clock, one bit per half |
| ba_oe_n | input | 2 | B-to-A output enable, active low, one bit per half |
| b_out | output | 18 | B-port data, zero when disabled |
| b_oe | output | 18 | B-port per-bit drive flag |
| a_out | output | 18 | A-port data, zero when disabled |
| a_oe | output | 18 | A-port per-bit drive flag |

## Verification
The hardest case to reach is a latch-enable fall that lands on the same `clk` edge as a storage-clock rise. Only a design with the capture rule takes the new word there. A design that keeps the last transparent value does not. The bench holds the element transparent on one word. At a single falling edge of `clk` it then drops the latch enable, raises the storage clock and presents a second word. It reads the output after the next rising edge, and again after the source has changed. A second awkward case is reset released with the storage clock already high; the bench holds the clock high through reset to show that no false capture follows.

// File: rtl/ubus_xcvr_pkg.sv
package ubus_xcvr_pkg;
    typedef enum logic [0:0] {
        ST_HOLD = 1'b0,
        ST_PASS = 1'b1
    } store_mode_t;
endpackage

// File: rtl/ubus_store.sv
module ubus_store
    import ubus_xcvr_pkg::*;
#(
    parameter int WIDTH = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             le,
    input  logic             ck,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    store_mode_t     mode;
    logic            ck_prev;
    logic            load;
    logic [WIDTH-1:0] held;

    // mode decode and load decision (T_OPEN/T_CLOSE/T_CAPTURE/T_KEEP)
    always_comb begin
        mode = le ? ST_PASS : ST_HOLD;
        load = 1'b0;
        unique case (mode)
            ST_PASS: load = 1'b1;
            ST_HOLD: load = ck & ~ck_prev;
            default: load = 1'b0;
        endcase
    end

    // state register: stored word and last storage-clock sample
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            held    <= '0;
            ck_prev <= 1'b1;
        end else begin
            ck_prev <= ck;
            if (load) held <= d;
        end
    end

    // output process
    always_comb begin
        unique case (mode)
            ST_PASS: q = d;
            ST_HOLD: q = held;
            default: q = held;
        endcase
    end
endmodule

// File: rtl/ubus_drive.sv
module ubus_drive #(
    parameter int WIDTH = 9
) (
    input  logic             oe_n,
    input  logic [WIDTH-1:0] val,
    output logic [WIDTH-1:0] dout,
    output logic [WIDTH-1:0] doe
);
    always_comb begin
        dout = oe_n ? '0 : val;
        doe  = {WIDTH{~oe_n}};
    end
endmodule

// File: rtl/ubus_xcvr.sv
module ubus_xcvr #(
    parameter int HALF_W = 9,
    parameter int HALVES = 2,
    localparam int W = HALF_W * HALVES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [W-1:0]      a_in,
    input  logic [W-1:0]      b_in,
    input  logic [HALVES-1:0] ab_le,
    input  logic [HALVES-1:0] ab_ck,
    input  logic [HALVES-1:0] ab_oe_n,
    input  logic [HALVES-1:0] ba_le,
    input  logic [HALVES-1:0] ba_ck,
    input  logic [HALVES-1:0] ba_oe_n,
    output logic [W-1:0]      b_out,
    output logic [W-1:0]      b_oe,
    output logic [W-1:0]      a_out,
    output logic [W-1:0]      a_oe
);
    for (genvar h = 0; h < HALVES; h++) begin : g_half
        logic [HALF_W-1:0] ab_val;
        logic [HALF_W-1:0] ba_val;

        ubus_store #(.WIDTH(HALF_W)) u_ab_store (
            .clk  (clk),
            .rst_n(rst_n),
            .le   (ab_le[h]),
            .ck   (ab_ck[h]),
            .d    (a_in[h*HALF_W +: HALF_W]),
            .q    (ab_val)
        );

        ubus_store #(.WIDTH(HALF_W)) u_ba_store (
            .clk  (clk),
            .rst_n(rst_n),
            .le   (ba_le[h]),
            .ck   (ba_ck[h]),
            .d    (b_in[h*HALF_W +: HALF_W]),
            .q    (ba_val)
        );

        ubus_drive #(.WIDTH(HALF_W)) u_ab_drive (
            .oe_n(ab_oe_n[h]),
            .val (ab_val),
            .dout(b_out[h*HALF_W +: HALF_W]),
            .doe (b_oe[h*HALF_W +: HALF_W])
        );

        ubus_drive #(.WIDTH(HALF_W)) u_ba_drive (
            .oe_n(ba_oe_n[h]),
            .val (ba_val),
            .dout(a_out[h*HALF_W +: HALF_W]),
            .doe (a_oe[h*HALF_W +: HALF_W])
        );
    end
endmodule

// File: rtl/ubus_xcvr_chk.sv
module ubus_dir_chk #(
    parameter int WIDTH = 9
) (
    input logic             clk,
    input logic             rst_n,
    input logic             le,
    input logic             ck,
    input logic             oe_n,
    input logic [WIDTH-1:0] din,
    input logic [WIDTH-1:0] dout,
    input logic [WIDTH-1:0] doe
);
    AST_PASS_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        (le && !oe_n) |-> (dout == din)); // R1

    AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!le && !oe_n && $past(!le && !oe_n) && !($past(ck) && !$past(ck, 2)))
        |-> $stable(dout)); // R2

    AST_EDGE_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
        (!le && !oe_n && $past(!le && ck && rst_n) && !$past(ck, 2) && $past(rst_n, 2))
        |-> (dout == $past(din))); // R3

    AST_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        oe_n |-> (dout == '0 && doe == '0)); // R4

    AST_ON_DRIVES: assert property (@(posedge clk) disable iff (!rst_n)
        !oe_n |-> (doe == '1)); // R4
endmodule

module ubus_xcvr_chk #(
    parameter int HALF_W = 9,
    parameter int HALVES = 2,
    localparam int W = HALF_W * HALVES
) (
    input logic              clk,
    input logic              rst_n,
    input logic [W-1:0]      a_in,
    input logic [W-1:0]      b_in,
    input logic [HALVES-1:0] ab_le,
    input logic [HALVES-1:0] ab_ck,
    input logic [HALVES-1:0] ab_oe_n,
    input logic [HALVES-1:0] ba_le,
    input logic [HALVES-1:0] ba_ck,
    input logic [HALVES-1:0] ba_oe_n,
    input logic [W-1:0]      b_out,
    input logic [W-1:0]      b_oe,
    input logic [W-1:0]      a_out,
    input logic [W-1:0]      a_oe
);
    for (genvar h = 0; h < HALVES; h++) begin : g_chk
        ubus_dir_chk #(.WIDTH(HALF_W)) u_ab (
            .clk (clk), .rst_n(rst_n),
            .le  (ab_le[h]), .ck(ab_ck[h]), .oe_n(ab_oe_n[h]),
            .din (a_in[h*HALF_W +: HALF_W]),
            .dout(b_out[h*HALF_W +: HALF_W]),
            .doe (b_oe[h*HALF_W +: HALF_W])
        );
        ubus_dir_chk #(.WIDTH(HALF_W)) u_ba (
            .clk (clk), .rst_n(rst_n),
            .le  (ba_le[h]), .ck(ba_ck[h]), .oe_n(ba_oe_n[h]),
            .din (b_in[h*HALF_W +: HALF_W]),
            .dout(a_out[h*HALF_W +: HALF_W]),
            .doe (a_oe[h*HALF_W +: HALF_W])
        );
    end
endmodule

bind ubus_xcvr ubus_xcvr_chk #(.HALF_W(HALF_W), .HALVES(HALVES)) u_chk (
    .clk(clk), .rst_n(rst_n), .a_in(a_in), .b_in(b_in),
    .ab_le(ab_le), .ab_ck(ab_ck), .ab_oe_n(ab_oe_n),
    .ba_le(ba_le), .ba_ck(ba_ck), .ba_oe_n(ba_oe_n),
    .b_out(b_out), .b_oe(b_oe), .a_out(a_out), .a_oe(a_oe)
);

// File: tb/ubus_xcvr_test.sv
module ubus_xcvr_test;
    localparam int HW = 9;
    localparam int NH = 2;
    localparam int W  = HW * NH;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [W-1:0]  a_in = '0, b_in = '0;
    logic [NH-1:0] ab_le = '0, ab_ck = '0, ab_oe_n = '0;
    logic [NH-1:0] ba_le = '0, ba_ck = '0, ba_oe_n = '0;
    logic [W-1:0]  b_out, b_oe, a_out, a_oe;

    int n_cmp = 0;
    int n_bad = 0;

    ubus_xcvr #(.HALF_W(HW), .HALVES(NH)) uut (
        .clk(clk), .rst_n(rst_n), .a_in(a_in), .b_in(b_in),
        .ab_le(ab_le), .ab_ck(ab_ck), .ab_oe_n(ab_oe_n),
        .ba_le(ba_le), .ba_ck(ba_ck), .ba_oe_n(ba_oe_n),
        .b_out(b_out), .b_oe(b_oe), .a_out(a_out), .a_oe(a_oe)
    );

    always #10 clk = ~clk;

    task automatic chk(input string tag, input logic [W-1:0] got, input logic [W-1:0] exp);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s actual %h expected %h", tag, got, exp);
        end
    endtask

    task automatic t_reset();
        ab_ck = '1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        a_in  = 18'h3FFFF;
        repeat (2) @(negedge clk);
        chk("R8 b_out after reset, ck held high", b_out, '0);
        chk("R8 a_out after reset", a_out, '0);
        chk("R4 b_oe on", b_oe, '1);
        ab_ck = '0;
    endtask

    task automatic t_transparent();
        @(negedge clk);
        ab_le = '1; a_in = 18'h12345;
        #1 chk("R1 follow 1", b_out, 18'h12345);
        a_in = 18'h2ABCD;
        #1 chk("R1 follow 2", b_out, 18'h2ABCD);
    endtask

    task automatic t_latch();
        @(negedge clk);
        ab_le = '0; a_in = 18'h00FF0;
        repeat (3) @(negedge clk);
        chk("R2 hold", b_out, 18'h2ABCD);
    endtask

    task automatic t_clocked();
        a_in = 18'h15A5A; ab_ck = '1;
        @(negedge clk);
        chk("R3 capture on rise", b_out, 18'h15A5A);
        a_in = 18'h3C3C3;
        @(negedge clk);
        chk("R3 clock held high no load", b_out, 18'h15A5A);
        ab_ck = '0;
        @(negedge clk);
        chk("R3 clock fall no load", b_out, 18'h15A5A);
        a_in = 18'h0F0F0; ab_ck = '1;
        @(negedge clk);
        chk("R3 second capture", b_out, 18'h0F0F0);
        ab_ck = '0;
    endtask

    task automatic t_hiz();
        ab_oe_n = '1;
        #1 chk("R4 off data zero", b_out, '0);
        chk("R4 off flags zero", b_oe, '0);
        a_in = 18'h11111;
        @(negedge clk);
        ab_oe_n = '0;
        #1 chk("R4 storage kept while off", b_out, 18'h0F0F0);
        chk("R4 flags on", b_oe, '1);
    endtask

    task automatic t_ba();
        @(negedge clk);
        b_in = 18'h1E1E1; ba_le = '1;
        #1 chk("R5 a_out transparent", a_out, 18'h1E1E1);
        @(negedge clk);
        ba_le = '0; b_in = 18'h00001;
        @(negedge clk);
        chk("R5 a_out hold", a_out, 18'h1E1E1);
        b_in = 18'h2D2D2; ba_ck = '1;
        @(negedge clk);
        chk("R5 a_out capture", a_out, 18'h2D2D2);
        ba_oe_n = '1;
        #1 chk("R5 a_out off", a_out, '0);
        chk("R5 a_oe off", a_oe, '0);
        chk("R5 b_out untouched", b_out, 18'h0F0F0);
        ba_oe_n = '0; ba_ck = '0;
    endtask

    task automatic t_halves();
        @(negedge clk);
        ab_le = 2'b01; a_in = {9'h1AA, 9'h055};
        #1 chk("R6 half0 pass, half1 hold", b_out, {9'h078, 9'h055});
        @(negedge clk);
        a_in = {9'h0C3, 9'h13C}; ab_ck = 2'b10;
        @(negedge clk);
        chk("R6 half1 clocked", b_out, {9'h0C3, 9'h13C});
        ab_oe_n = 2'b01;
        #1 chk("R6 half0 off only", b_out, {9'h0C3, 9'h000});
        chk("R6 flags per half", b_oe, {9'h1FF, 9'h000});
        ab_oe_n = '0; ab_ck = '0; ab_le = '0;
    endtask

    task automatic t_coincide();
        @(negedge clk);
        ab_le = '1; a_in = 18'h11111;
        @(negedge clk);
        ab_le = '0; ab_ck = '1; a_in = 18'h22222;
        @(negedge clk);
        chk("R7 fall with rise captures", b_out, 18'h22222);
        a_in = 18'h33333;
        @(negedge clk);
        chk("R7 then holds", b_out, 18'h22222);
        ab_ck = '0;
    endtask

    task automatic t_async_reset();
        @(negedge clk);
        #3 rst_n = 1'b0;
        #1 chk("R8 async clear b_out", b_out, '0);
        chk("R8 async clear a_out", a_out, '0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R8 stays clear", b_out, '0);
    endtask

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        #(200000 * 20);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        t_reset();
        t_transparent();
        t_latch();
        t_clocked();
        t_hiz();
        t_ba();
        t_halves();
        t_coincide();
        t_async_reset();
        finish_run();
    end
endmodule